// File: doc/BRIEF.md
# 8x8 Unsigned Multiplier with 4:2 Compressor Reduction

This block multiplies two 8-bit unsigned operands and returns the full 16-bit product in the same cycle, with no clock and no state. It forms eight partial-product rows by ANDing the multiplicand with each multiplier bit. It then cuts the height of that array in two levels of tiled 4:2 counters, from eight rows to four and from four rows to two. One carry-propagate adder sums the last two rows.

Each 4:2 counter is two chained 3:2 counters. It takes four bits of equal weight and one lateral carry from its lower-weight neighbour in the same row. It returns a sum bit, a carry bit for the reduced carry row, and a lateral carry for its higher neighbour. That lateral carry does not depend on the incoming lateral carry, so it never ripples along a row. Counters sit only on columns where three or more rows can overlap, or where a lateral carry still has to be absorbed. Elsewhere bits pass straight into the two output rows.

Top module: `mul42_tree`

## Requirements
- R1: For every pair of operands, `prod_o` equals the unsigned product of `a_i` and `b_i` as a 16-bit value.
- R2: When either operand is zero, `prod_o` is zero.
- R3: When one operand is 1, `prod_o` equals the other operand zero-extended to 16 bits.
- R4: With both operands at 0xFF, `prod_o` is 0xFE01 (bit 15 set, no wrap).
- R5: The final adder adds the two reduced rows with a carry that can travel through all 16 positions, and it drops the carry out of bit 15. A product of two powers of two, 2^i times 2^j, therefore has exactly bit i+j set.
- R6: Each first-level counter row takes the four partial-product rows of one multiplier nibble. Its two output rows sum to `a_i` times that nibble, shifted left by four times the nibble index. Nibble 0 is `b_i[3:0]` and nibble 1 is `b_i[7:4]`. With one nibble zero, the product equals the contribution of the other nibble alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 8 | Multiplicand, unsigned |
| b_i | input | 8 | Multiplier, unsigned |
| prod_o | output | 16 | Full-width unsigned product |

## Verification
Two carry mechanisms act on the same evaluation: the lateral carries between neighbouring 4:2 counters inside a reduction row, and the ripple carry of the final adder. Both can be long at once. All-ones operands and dense random patterns turn on every lateral carry and also drive a carry through most of the final adder. The products of powers of two and the single-nibble multipliers isolate each level. Every pair of operands is also applied, and each product is compared with a shift-and-add model in the bench.

// File: rtl/mul42_pkg.sv
package mul42_pkg;

  localparam int unsigned GRP_ROWS = 4;

  typedef struct packed {
    logic carry;
    logic sum;
  } csa_out_t;

  // 3:2 count of ones: low bit is sum, high bit is carry
  function automatic csa_out_t csa32_f(logic x, logic y, logic z);
    csa_out_t r;
    r.sum   = x ^ y ^ z;
    r.carry = (x & y) | (x & z) | (y & z);
    return r;
  endfunction

endpackage

// File: rtl/mul42_csa32.sv
module mul42_csa32
  import mul42_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic z_i,
  output logic sum_o,
  output logic carry_o
);

  csa_out_t res;

  assign res     = csa32_f(x_i, y_i, z_i);
  assign sum_o   = res.sum;
  assign carry_o = res.carry;

endmodule

// File: rtl/mul42_c42_cell.sv
module mul42_c42_cell (
  input  logic [3:0] x_i,
  input  logic       cin_i,
  output logic       sum_o,
  output logic       carry_o,
  output logic       cout_o
);

  logic mid;

  // cout_o does not depend on cin_i, so lateral carries never ripple
  mul42_csa32 u_lo (
    .x_i    (x_i[0]),
    .y_i    (x_i[1]),
    .z_i    (x_i[2]),
    .sum_o  (mid),
    .carry_o(cout_o)
  );

  mul42_csa32 u_hi (
    .x_i    (mid),
    .y_i    (x_i[3]),
    .z_i    (cin_i),
    .sum_o  (sum_o),
    .carry_o(carry_o)
  );

endmodule

// File: rtl/mul42_c42_row.sv
// One tiled row of 4:2 counters over columns LO..HI.
// Contract: row_i[2] and row_i[3] are zero below LO, all rows are zero above HI.
// Both outputs are aligned to column weight (c_o already shifted).
module mul42_c42_row #(
  parameter int W  = 16,
  parameter int LO = 2,
  parameter int HI = 10
) (
  input  logic [3:0][W-1:0] row_i,
  output logic [W-1:0]      s_o,
  output logic [W-1:0]      c_o
);

  logic [HI+1:LO] chain;
  logic [W:0]     c_full;
  logic           unused_top;

  assign chain[LO]  = 1'b0;
  assign c_full[LO] = 1'b0;

  for (genvar j = 0; j < W; j++) begin : g_col
    if (j >= LO && j <= HI) begin : g_cnt
      mul42_c42_cell u_cell (
        .x_i    ({row_i[3][j], row_i[2][j], row_i[1][j], row_i[0][j]}),
        .cin_i  (chain[j]),
        .sum_o  (s_o[j]),
        .carry_o(c_full[j+1]),
        .cout_o (chain[j+1])
      );
    end else if (j < LO) begin : g_low
      assign s_o[j]    = row_i[0][j] | row_i[2][j] | row_i[3][j];
      assign c_full[j] = row_i[1][j];
    end else if (j == HI + 1) begin : g_edge
      assign s_o[j] = chain[j] | row_i[0][j] | row_i[1][j] | row_i[2][j] | row_i[3][j];
    end else begin : g_high
      assign s_o[j]    = row_i[0][j] | row_i[2][j] | row_i[3][j];
      assign c_full[j] = row_i[1][j];
    end
  end

  if (HI < W - 1) begin : g_pad
    assign c_full[W] = 1'b0;
  end

  assign c_o        = c_full[W-1:0];
  assign unused_top = c_full[W] ^ chain[HI+1];

endmodule

// File: rtl/mul42_cpa.sv
module mul42_cpa #(
  parameter int W = 16
) (
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] sum_o
);

  logic [W:0] cy;
  logic       unused_cout;

  assign cy[0] = 1'b0;

  for (genvar j = 0; j < W; j++) begin : g_bit
    mul42_csa32 u_fa (
      .x_i    (s_i[j]),
      .y_i    (c_i[j]),
      .z_i    (cy[j]),
      .sum_o  (sum_o[j]),
      .carry_o(cy[j+1])
    );
  end

  assign unused_cout = cy[W];

endmodule

// File: rtl/mul42_tree.sv
// Two reduction levels: supports OP_W = 8 (two nibble groups).
module mul42_tree
  import mul42_pkg::*;
#(
  parameter int unsigned OP_W = 8
) (
  input  logic [OP_W-1:0]   a_i,
  input  logic [OP_W-1:0]   b_i,
  output logic [2*OP_W-1:0] prod_o
);

  localparam int unsigned P_W   = 2 * OP_W;
  localparam int unsigned N_GRP = OP_W / GRP_ROWS;

  logic [OP_W-1:0][P_W-1:0]  pp;
  logic [N_GRP-1:0][P_W-1:0] l1_s;
  logic [N_GRP-1:0][P_W-1:0] l1_c;
  logic [P_W-1:0]            red_s;
  logic [P_W-1:0]            red_c;

  for (genvar r = 0; r < OP_W; r++) begin : g_pp
    assign pp[r] = P_W'({OP_W{b_i[r]}} & a_i) << r;
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_l1
    mul42_c42_row #(
      .W (P_W),
      .LO(GRP_ROWS * g + 2),
      .HI(GRP_ROWS * g + OP_W + 2)
    ) u_row (
      .row_i(pp[GRP_ROWS*g +: GRP_ROWS]),
      .s_o  (l1_s[g]),
      .c_o  (l1_c[g])
    );
  end

  mul42_c42_row #(
    .W (P_W),
    .LO(GRP_ROWS),
    .HI(P_W - 1)
  ) u_l2 (
    .row_i({l1_c[1], l1_s[1], l1_c[0], l1_s[0]}),
    .s_o  (red_s),
    .c_o  (red_c)
  );

  mul42_cpa #(
    .W(P_W)
  ) u_cpa (
    .s_i  (red_s),
    .c_i  (red_c),
    .sum_o(prod_o)
  );

endmodule

// File: rtl/mul42_tree_chk.sv
module mul42_tree_chk #(
  parameter int unsigned OP_W = 8
) (
  input logic [OP_W-1:0]         a_i,
  input logic [OP_W-1:0]         b_i,
  input logic [2*OP_W-1:0]       prod_o,
  input logic [1:0][2*OP_W-1:0]  l1_s,
  input logic [1:0][2*OP_W-1:0]  l1_c,
  input logic [2*OP_W-1:0]       red_s,
  input logic [2*OP_W-1:0]       red_c
);

  localparam int unsigned P_W = 2 * OP_W;
  localparam logic [P_W-1:0] MAX_SQ =
    {{(OP_W-1){1'b1}}, 1'b0, {(OP_W-1){1'b0}}, 1'b1};

  always_comb begin
    p_product_r1: assert (prod_o == P_W'(a_i) * P_W'(b_i))
      else $error("R1 product mismatch");
    p_zero_op_r2: assert (!(a_i == '0 || b_i == '0) || prod_o == '0)
      else $error("R2 zero operand");
    p_unit_a_r3: assert (a_i != OP_W'(1) || prod_o == P_W'(b_i))
      else $error("R3 unit multiplicand");
    p_unit_b_r3: assert (b_i != OP_W'(1) || prod_o == P_W'(a_i))
      else $error("R3 unit multiplier");
    p_max_sq_r4: assert (!(&a_i && &b_i) || prod_o == MAX_SQ)
      else $error("R4 max square");
    p_rows_cpa_r5: assert (P_W'(red_s + red_c) == prod_o)
      else $error("R5 final adder");
  end

  for (genvar g = 0; g < 2; g++) begin : g_grp
    always_comb begin
      p_group_sum_r6: assert (P_W'(l1_s[g] + l1_c[g]) ==
                              ((P_W'(a_i) * P_W'(b_i[4*g +: 4])) << (4 * g)))
        else $error("R6 group row sum");
    end
  end

endmodule

bind mul42_tree mul42_tree_chk #(.OP_W(OP_W)) u_chk (
  .a_i   (a_i),
  .b_i   (b_i),
  .prod_o(prod_o),
  .l1_s  (l1_s),
  .l1_c  (l1_c),
  .red_s (red_s),
  .red_c (red_c)
);

// File: tb/sim_mul42_tree.sv
`timescale 1ns/1ps
module sim_mul42_tree;

  localparam int OP_W = 8;
  localparam int P_W  = 16;

  logic            clk = 1'b0;
  logic            rst_ni;
  logic [OP_W-1:0] a;
  logic [OP_W-1:0] b;
  logic [P_W-1:0]  prod;
  int              checks = 0;
  int              fails  = 0;
  bit              done   = 1'b0;

  always #10 clk = ~clk;

  mul42_tree u0 (
    .a_i   (a),
    .b_i   (b),
    .prod_o(prod)
  );

  function automatic logic [P_W-1:0] ref_mul(logic [OP_W-1:0] x, logic [OP_W-1:0] y);
    logic [P_W-1:0] acc = '0;
    for (int i = 0; i < OP_W; i++)
      if (y[i]) acc = acc + (P_W'(x) << i);
    return acc;
  endfunction

  task automatic check(string req, logic [P_W-1:0] act, logic [P_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s a=%02h b=%02h actual=%04h expected=%04h", req, a, b, act, exp);
    end
  endtask

  task automatic apply(logic [OP_W-1:0] x, logic [OP_W-1:0] y);
    @(posedge clk);
    a = x;
    b = y;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    a = '0;
    b = '0;
    @(negedge clk);
    check("R2 reset idle", prod, 16'h0000);
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;

    // R2: zero operands
    apply(8'h00, 8'hA7); check("R2 a zero", prod, 16'h0000);
    apply(8'h5C, 8'h00); check("R2 b zero", prod, 16'h0000);
    apply(8'h00, 8'hFF); check("R2 a zero full b", prod, 16'h0000);

    // R3: unit operands
    apply(8'h01, 8'hC3); check("R3 a one", prod, 16'h00C3);
    apply(8'hFF, 8'h01); check("R3 b one", prod, 16'h00FF);

    // R4: largest operands
    apply(8'hFF, 8'hFF); check("R4 max square", prod, 16'hFE01);

    // R5: long carries and power-of-two products
    apply(8'h80, 8'h80); check("R5 top bit only", prod, 16'h4000);
    apply(8'hFF, 8'h81); check("R5 long carry", prod, 16'h807F);
    for (int i = 0; i < OP_W; i++)
      for (int j = 0; j < OP_W; j++) begin
        apply(OP_W'(1) << i, OP_W'(1) << j);
        check("R5 power of two", prod, P_W'(1) << (i + j));
      end

    // R6: one multiplier nibble at a time
    apply(8'hFF, 8'h0F); check("R6 low nibble", prod, 16'h0EF1);
    apply(8'hFF, 8'hF0); check("R6 high nibble", prod, 16'hEF10);
    apply(8'hB5, 8'h09); check("R6 low nibble mixed", prod, 16'h065D);
    apply(8'hB5, 8'h90); check("R6 high nibble mixed", prod, 16'h65D0);

    // R1: constrained random, fixed seed
    void'($urandom(32'd20240611));
    for (int k = 0; k < 2000; k++) begin
      logic [OP_W-1:0] x;
      logic [OP_W-1:0] y;
      x = OP_W'($urandom);
      y = OP_W'($urandom);
      if (k % 4 == 0) x = x | 8'hF0;
      if (k % 5 == 0) y = y | 8'h81;
      apply(x, y);
      check("R1 random", prod, ref_mul(x, y));
    end

    // R1: every operand pair
    for (int x = 0; x < 256; x++)
      for (int y = 0; y < 256; y++) begin
        apply(OP_W'(x), OP_W'(y));
        check("R1 exhaustive", prod, ref_mul(OP_W'(x), OP_W'(y)));
      end

    finish_run();
  end

endmodule